// File: doc/BRIEF.md
# Framed Serial Transmitter on a Word Shifter

This block sends asynchronous serial characters by building each character into one fixed-length word and shifting it out least significant bit first through a synchronous shifter. For each character the host supplies the data byte, a character size of 5 to 8 bits and a choice of one or two stop bits. The block puts a low start bit in bit 0, keeps only the chosen number of data bits, and forces the stop bits high above them. The finished word enters a small FIFO, passes through a holding register, and reaches the shift register. The shift register drives the line at a bit period set by a divider input.

Words run back to back with no idle gap for as long as the transmitter is enabled. To finish a burst cleanly, the host queues an all-ones fill word after the last character. When the fill word reaches the shifter, the real character has already left. The host may then clear the enable with the line still high. If the host leaves the enable on and the shifter runs dry, an underflow is flagged. A write into a full FIFO is dropped and flagged as an overflow. Both errors switch the transmitter off.

Top module: `uart_word_tx`

## Requirements
- R1: After reset, `txd` is 1, `tx_active` is 0, `hold_empty` is 1, and `fifo_full`, `tx_overflow` and `tx_underflow` are 0.
- R2: A character word carries a 0 start bit first, followed by the data bits least significant first. `wr_size` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits, and data bits above the selected size are dropped.
- R3: One stop bit (`wr_two_stop`=0) or two stop bits (`wr_two_stop`=1), each at 1, follow the data bits. The word is therefore size + stops + 1 bits long.
- R4: Every bit stays on `txd` for exactly 2*(`div`+1) clock cycles. The first word's start bit appears one clock after the cycle in which `en_set` is sampled.
- R5: Queued words leave in write order, and each word's first bit follows the previous word's last bit with no idle time.
- R6: `txd` is 1 whenever `tx_active` is 0 or no word is in the shifter. Turning the transmitter off in the middle of a word drives the line to 1 at once and discards the rest of that word.
- R7: A write with `wr_fill`=1 queues a word of all ones, with the length given by `wr_size` and `wr_two_stop`, so the line stays at 1 for that whole time.
- R8: `hold_empty` is 1 exactly when both the FIFO and the holding register are empty.
- R9: `fifo_full` is 1 when the FIFO holds DEPTH words. The holding register is separate, so DEPTH+1 words can wait while the transmitter is off.
- R10: A write while `fifo_full` is 1 is dropped. It sets `tx_overflow` and turns the transmitter off.
- R11: If the last bit of a word ends while the transmitter is on and the holding register is empty, `tx_underflow` is set and the transmitter turns off.
- R12: `en_set` turns the transmitter on and clears both error flags. `en_clr` turns it off and wins over `en_set` in the same cycle. An error event in a cycle wins over `en_set`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_set | input | 1 | Pulse: turn transmitter on, clear error flags |
| en_clr | input | 1 | Pulse: turn transmitter off |
| div | input | DIV_W | Bit-rate divider; bit period is 2*(div+1) clocks |
| wr_valid | input | 1 | Write strobe for one word |
| wr_data | input | 8 | Character data |
| wr_size | input | 2 | Character size code (0..3 means 5..8 bits) |
| wr_two_stop | input | 1 | 1 selects two stop bits |
| wr_fill | input | 1 | 1 queues an all-ones fill word instead of a character |
| txd | output | 1 | Serial line output |
| tx_active | output | 1 | Transmitter enabled |
| fifo_full | output | 1 | FIFO holds DEPTH words |
| hold_empty | output | 1 | FIFO and holding register both empty |
| tx_overflow | output | 1 | Sticky: a write hit a full FIFO |
| tx_underflow | output | 1 | Sticky: the shifter ran dry while enabled |

## Verification
The hardest case to reach is an overflow that lands in the very cycle the shifter takes its first word. Making the dropped write visible afterwards is harder still, because nothing on the ports shows the FIFO's contents. The bench fills the FIFO and the holding register while the transmitter is off. It then enables the block and writes one more word on the next clock, so the write meets a full FIFO just as the first word is aborted. It re-enables the block, and a scoreboard checks every bit of the remaining eight distinct words. Underflow must then follow on the exact clock after the last of those words. A stored overflow word would both add bits and delay the underflow.

// File: rtl/uart_word_tx_pkg.sv
// Shared sizes, the queued word type and the frame builder for uart_word_tx.
// Assumes characters of DATA_MIN..DATA_MAX bits and one or two stop bits.
package uart_word_tx_pkg;

    localparam int DATA_MAX = 8;
    localparam int DATA_MIN = 5;
    localparam int SIZE_W   = $clog2(DATA_MAX - DATA_MIN + 1);
    localparam int WORD_MAX = DATA_MAX + 3;
    localparam int LEN_W    = $clog2(WORD_MAX + 1);

    // One queued word: serial bits (bit 0 sent first) and the number of bits to send.
    typedef struct packed {
        logic [WORD_MAX-1:0] bits;
        logic [LEN_W-1:0]    len;
    } tx_word_t;

    // Build a word: 0 start bit at bit 0, data above it, all higher bits 1.
    // The stop bits come from those forced ones. A fill word is all ones.
    function automatic tx_word_t build_word(
        input logic [DATA_MAX-1:0] data,
        input logic [SIZE_W-1:0]   code,
        input logic                two_stop,
        input logic                fill
    );
        tx_word_t    w;
        int unsigned n;
        n      = 32'(DATA_MIN) + 32'(code);
        w.bits = '1;
        if (!fill) begin
            w.bits[0] = 1'b0;
            for (int i = 0; i < DATA_MAX; i++) begin
                if (i < int'(n)) begin
                    w.bits[i+1] = data[i];
                end
            end
        end
        w.len = LEN_W'(n + 32'd2 + 32'(two_stop));
        return w;
    endfunction

endpackage

// File: rtl/uart_word_tx_fifo.sv
// Word FIFO between the write port and the holding register.
// Assumes the owner never pushes when full and never pops when empty.
module uart_word_tx_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign rdata = mem[rd_ptr];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= ptr_next(wr_ptr);
            if (pop)  rd_ptr <= ptr_next(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_no_push_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    assert_no_pop_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);
    assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

endmodule

// File: rtl/uart_word_tx_baud.sv
// Bit-rate counter: while run is high, ticks once every 2*(div+1) clocks.
// Assumes div is held steady while run is high.
module uart_word_tx_baud #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W:0] cnt;
    logic [DIV_W:0] last_idx;

    assign last_idx = {div, 1'b1};
    assign tick     = run && (cnt == last_idx);

    // Count clocks within the current bit; restart on each tick or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= last_idx));

endmodule

// File: rtl/uart_word_tx_shifter.sv
// Output shift register. It takes a word from the holding register and sends
// it LSB first. A new word loads in the tick that ends the last bit, so words
// run back to back. The line is held high when disabled or idle.
// Assumes the tick comes from a counter that runs only while busy.
module uart_word_tx_shifter
    import uart_word_tx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  logic     tick,
    input  logic     hold_valid,
    input  tx_word_t hold_word,
    output logic     take,
    output logic     busy,
    output logic     underflow_evt,
    output logic     txd
);
    logic [WORD_MAX-1:0] shreg;
    logic [LEN_W-1:0]    left;
    logic                last_bit;

    assign last_bit      = busy && tick && (left == LEN_W'(1));
    assign take          = en && hold_valid && (!busy || last_bit);
    assign underflow_evt = en && last_bit && !hold_valid;
    assign txd           = (en && busy) ? shreg[0] : 1'b1;

    // Load, shift or drop the current word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '1;
            left  <= '0;
            busy  <= 1'b0;
        end else if (!en) begin
            shreg <= '1;
            busy  <= 1'b0;
        end else if (take) begin
            shreg <= hold_word.bits;
            left  <= hold_word.len;
            busy  <= 1'b1;
        end else if (last_bit) begin
            shreg <= '1;
            busy  <= 1'b0;
        end else if (busy && tick) begin
            shreg <= {1'b1, shreg[WORD_MAX-1:1]};
            left  <= left - 1'b1;
        end
    end

    assert_disable_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !busy);
    assert_bit_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && en && !tick) |=> $stable(shreg));

endmodule

// File: rtl/uart_word_tx.sv
// Top of the framed serial transmitter. It builds words from the write port,
// queues them in the FIFO and a holding register, and feeds the shifter. It
// also keeps the enable and the sticky overflow and underflow flags.
// Assumes en_set and en_clr are single-cycle pulses.
module uart_word_tx
    import uart_word_tx_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DIV_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_set,
    input  logic                en_clr,
    input  logic [DIV_W-1:0]    div,
    input  logic                wr_valid,
    input  logic [DATA_MAX-1:0] wr_data,
    input  logic [SIZE_W-1:0]   wr_size,
    input  logic                wr_two_stop,
    input  logic                wr_fill,
    output logic                txd,
    output logic                tx_active,
    output logic                fifo_full,
    output logic                hold_empty,
    output logic                tx_overflow,
    output logic                tx_underflow
);
    localparam int WW = $bits(tx_word_t);

    tx_word_t new_word, fifo_word, hold_word;
    logic     fifo_empty, push, pop, hold_v;
    logic     take, busy, tick, unf_evt, ovf_evt, en_q;

    assign new_word   = build_word(wr_data, wr_size, wr_two_stop, wr_fill);
    assign push       = wr_valid && !fifo_full;
    assign ovf_evt    = wr_valid && fifo_full;
    assign pop        = !fifo_empty && (!hold_v || take);
    assign hold_empty = !hold_v && fifo_empty;
    assign tx_active  = en_q;

    uart_word_tx_fifo #(.WIDTH(WW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata (new_word),
        .pop   (pop),
        .rdata (fifo_word),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    // Holding register: refilled from the FIFO when empty or being taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_v    <= 1'b0;
            hold_word <= '1;
        end else if (pop) begin
            hold_v    <= 1'b1;
            hold_word <= fifo_word;
        end else if (take) begin
            hold_v    <= 1'b0;
        end
    end

    uart_word_tx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .div   (div),
        .tick  (tick)
    );

    uart_word_tx_shifter u_shift (
        .clk           (clk),
        .rst_n         (rst_n),
        .en            (en_q),
        .tick          (tick),
        .hold_valid    (hold_v),
        .hold_word     (hold_word),
        .take          (take),
        .busy          (busy),
        .underflow_evt (unf_evt),
        .txd           (txd)
    );

    // Enable: turn-off requests and errors win over en_set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (en_clr || ovf_evt || unf_evt) begin
            en_q <= 1'b0;
        end else if (en_set) begin
            en_q <= 1'b1;
        end
    end

    // Sticky error flags: set by events, cleared by en_set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_overflow  <= 1'b0;
            tx_underflow <= 1'b0;
        end else begin
            if (ovf_evt)     tx_overflow  <= 1'b1;
            else if (en_set) tx_overflow  <= 1'b0;
            if (unf_evt)     tx_underflow <= 1'b1;
            else if (en_set) tx_underflow <= 1'b0;
        end
    end

    assert_ovf_disables_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && fifo_full) |=> (!tx_active && tx_overflow));
    assert_unf_disables_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_underflow) |-> !tx_active);
    assert_hold_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hold_empty |-> !fifo_full);

endmodule

// File: tb/uart_word_tx_bench.sv
// Scoreboard bench: the write task queues the expected serial bits, and the
// stream monitor pops them and compares them with txd on every falling edge.
module uart_word_tx_bench;
    localparam int DIV_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en_set = 1'b0, en_clr = 1'b0;
    logic [DIV_W-1:0] div = '0;
    logic             wr_valid = 1'b0;
    logic [7:0]       wr_data = '0;
    logic [1:0]       wr_size = '0;
    logic             wr_two_stop = 1'b0, wr_fill = 1'b0;
    logic             txd, tx_active, fifo_full, hold_empty, tx_overflow, tx_underflow;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    bit  exp_q[$];

    always #2 clk = ~clk;

    uart_word_tx #(.DEPTH(8), .DIV_W(DIV_W)) u_uart_word_tx (
        .clk(clk), .rst_n(rst_n), .en_set(en_set), .en_clr(en_clr), .div(div),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_size(wr_size),
        .wr_two_stop(wr_two_stop), .wr_fill(wr_fill), .txd(txd),
        .tx_active(tx_active), .fifo_full(fifo_full), .hold_empty(hold_empty),
        .tx_overflow(tx_overflow), .tx_underflow(tx_underflow)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Driver: one write, one cycle; pushes the expected bits when asked.
    task automatic put_word(input logic [7:0] d, input logic [1:0] code,
                            input logic two, input logic fill, input bit expect_it);
        int n;
        wr_data = d; wr_size = code; wr_two_stop = two; wr_fill = fill; wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
        if (expect_it) begin
            n = 5 + int'(code);
            exp_q.push_back(fill ? 1'b1 : 1'b0);
            for (int i = 0; i < n; i++) exp_q.push_back(fill ? 1'b1 : d[i]);
            exp_q.push_back(1'b1);
            if (two) exp_q.push_back(1'b1);
        end
    endtask

    // Pulse en_set and check that it took effect (R12).
    task automatic start_tx();
        en_set = 1'b1;
        @(negedge clk);
        en_set = 1'b0;
        chk("R12 enable on", int'(tx_active), 1);
        chk("R12 overflow cleared", int'(tx_overflow), 0);
        chk("R12 underflow cleared", int'(tx_underflow), 0);
    endtask

    // Monitor: the first bit starts on the next rising edge; every half-cycle
    // sample inside each bit period must match (R2 R3 R4 R5 R7).
    task automatic run_stream(input int bl);
        bit b;
        @(posedge clk);
        while (exp_q.size() > 0) begin
            b = exp_q.pop_front();
            for (int j = 0; j < bl; j++) begin
                @(negedge clk);
                chk("R2 R3 R4 R5 R7 stream bit", int'(txd), int'(b));
            end
        end
    endtask

    // Called just after the last expected bit: the underflow must follow now (R11).
    task automatic check_underflow();
        @(negedge clk);
        chk("R11 underflow flag", int'(tx_underflow), 1);
        chk("R11 disabled", int'(tx_active), 0);
        chk("R6 line idle high", int'(txd), 1);
        chk("R8 hold empty after drain", int'(hold_empty), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 txd", int'(txd), 1);
        chk("R1 tx_active", int'(tx_active), 0);
        chk("R1 hold_empty", int'(hold_empty), 1);
        chk("R1 fifo_full", int'(fifo_full), 0);
        chk("R1 overflow", int'(tx_overflow), 0);
        chk("R1 underflow", int'(tx_underflow), 0);

        // Mixed sizes, upper data bits dropped, fill word, bit period 4 clocks.
        div = 12'd1;
        put_word(8'hA5, 2'd3, 1'b0, 1'b0, 1'b1);
        put_word(8'hF3, 2'd0, 1'b1, 1'b0, 1'b1);
        put_word(8'h5A, 2'd2, 1'b0, 1'b0, 1'b1);
        put_word(8'h00, 2'd3, 1'b0, 1'b1, 1'b1);
        chk("R6 idle while disabled", int'(txd), 1);
        chk("R8 words waiting", int'(hold_empty), 0);
        start_tx();
        run_stream(4);
        check_underflow();

        // Bit period 6 clocks, six-bit and five-bit characters.
        div = 12'd2;
        put_word(8'h2C, 2'd1, 1'b1, 1'b0, 1'b1);
        put_word(8'h7F, 2'd0, 1'b0, 1'b0, 1'b1);
        start_tx();
        run_stream(6);
        check_underflow();

        // en_clr wins over en_set in the same cycle.
        en_set = 1'b1; en_clr = 1'b1;
        @(negedge clk);
        en_set = 1'b0; en_clr = 1'b0;
        chk("R12 clear wins", int'(tx_active), 0);

        // Fill FIFO and holding register while disabled (R9).
        div = 12'd0;
        put_word(8'h01, 2'd0, 1'b0, 1'b0, 1'b0);
        for (int k = 1; k < 8; k++) put_word(8'(k * 3 + 1), 2'd0, 1'b0, 1'b0, 1'b1);
        chk("R9 not yet full", int'(fifo_full), 0);
        put_word(8'h1E, 2'd0, 1'b0, 1'b0, 1'b1);
        chk("R9 full after DEPTH+1 writes", int'(fifo_full), 1);

        // Enable, then write while full as the first word loads (R10).
        en_set = 1'b1;
        @(negedge clk);
        en_set = 1'b0;
        wr_data = 8'h0B; wr_size = 2'd0; wr_two_stop = 1'b0; wr_fill = 1'b0; wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
        chk("R10 overflow flag", int'(tx_overflow), 1);
        chk("R10 disabled", int'(tx_active), 0);
        chk("R6 aborted word line high", int'(txd), 1);

        // Remaining eight words must play out, then underflow at once (R10 drop).
        start_tx();
        run_stream(2);
        check_underflow();

        report();
    end
endmodule